// File: doc/BRIEF.md
# Serial Transceiver Power-Down Controller

This block is the clocked control unit that sits beside a multi-channel serial line interface and decides when the line drivers, the main receiver outputs and the charge-pump supply are switched on. The analog side (thresholds, pumps, level shifting, protection) lives elsewhere. This block sees that side only through digital flags and the raw data lines.

Two manual controls decide the power state. An active-low kill input shuts everything down and takes priority over all else. An active-high keep-alive input stops any automatic shutdown. When neither control is active, one of two automatic policies applies, chosen by a parameter. In the signal-presence policy, the drivers turn off whenever no receiver reports a valid line level, and the receivers stay on. In the idle-timeout policy, the drivers and the main receivers turn off after a configurable time with no edge on any data line. Any edge wakes them again.

Some outputs never depend on the power state. An active-low "no signal" flag always reports whether any line is valid. A noninverted monitor copy of every receiver line is always driven. This flag can be wired back to both manual controls to emulate automatic power-down from outside.

Top module: `sercomm_pwr_ctl`

## Requirements
- R1: While `kill_n` is low, `supply_en`, `drv_en` and `rcv_en` are all 0, whatever the values of `keep_on`, `lvl_ok`, `rcv_oe_n` and the data lines.
- R2: While `kill_n` is high and `keep_on` is high, `supply_en` and `drv_en` are 1 in both policies, whatever the line validity or activity.
- R3: `nosig_n` is 1 when at least one bit of `lvl_ok` is 1 and 0 when all are 0. This holds in every power state, including while `kill_n` is low.
- R4: With POLICY=0 (signal presence), `kill_n` high and `keep_on` low, `drv_en` and `supply_en` are 0 while `nosig_n` is 0 and 1 while it is 1. `rcv_en` stays 1 (given `rcv_oe_n` low).
- R5: With POLICY=1 (idle timeout), `kill_n` high and `keep_on` low, `drv_en`, `supply_en` and `rcv_en` fall once IDLE_SEC*CLK_HZ cycles pass with no edge on any data line. They stay 1 until at least that many cycles after the last edge.
- R6: `rcv_en` is 0 whenever `rcv_oe_n` is 1, in every mode and independent of `drv_en`.
- R7: `mon_rx` equals `rx_line` (noninverted, bit for bit) in every mode, including while `kill_n` is low.
- R8: On wake-up, `supply_en` is 1 at least one clock before `drv_en` rises. `drv_en` never stays 1 after `supply_en` falls. A wake request cancelled after a single cycle never raises `drv_en`.
- R9: Reset clears all enables. Every asynchronous input passes two synchronizer flops. From a clean `kill_n` release, `supply_en` is first seen 1 at the third clock and `drv_en` at the fourth.
- R10: In POLICY=1, an edge on any transmit data line alone (no receive activity) restarts the idle timer and wakes a powered-down interface.
- R11: In POLICY=1 with `keep_on` high, `drv_en` and `rcv_en` stay 1 even after the idle time has elapsed with no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kill_n | input | 1 | Active-low forced shutdown, highest priority |
| keep_on | input | 1 | Active-high override of automatic shutdown |
| rcv_oe_n | input | 1 | Active-low enable of the main receiver outputs |
| lvl_ok | input | NRX | Per-receiver valid-line-level flags |
| tx_line | input | NTX | Raw transmit data lines, watched for edges |
| rx_line | input | NRX | Raw receive data lines, watched for edges |
| drv_en | output | 1 | Line driver enable |
| rcv_en | output | 1 | Main receiver output enable |
| supply_en | output | 1 | Charge-pump supply enable |
| mon_rx | output | NRX | Always-on noninverted receiver monitor |
| nosig_n | output | 1 | Low when no receiver sees a valid level |

## Verification
Two events can land in the same cycle: a forced shutdown and a wake-up that is still in progress. The bench releases `kill_n` and asserts it again one cycle later. The supply enable then rises for exactly one clock while the cancelled request is still in flight. The check is that `drv_en` never goes to 1, that the supply pulse lasts a single cycle, and that the ordering checker never sees the driver outrun the supply.

// File: rtl/sercomm_pwr_ctl.sv
module sercomm_pwr_ctl #(
  parameter int              NRX      = 3,
  parameter int              NTX      = 2,
  parameter int              POLICY   = 0,
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter longint unsigned IDLE_SEC = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           kill_n,
  input  logic           keep_on,
  input  logic           rcv_oe_n,
  input  logic [NRX-1:0] lvl_ok,
  input  logic [NTX-1:0] tx_line,
  input  logic [NRX-1:0] rx_line,
  output logic           drv_en,
  output logic           rcv_en,
  output logic           supply_en,
  output logic [NRX-1:0] mon_rx,
  output logic           nosig_n
);
  localparam longint unsigned LIMIT = CLK_HZ * IDLE_SEC;
  localparam int CW = $clog2(LIMIT + 1);
  localparam int NW = 3 + 2 * NRX + NTX;
  localparam bit TIMEOUT_MODE = (POLICY == 1);

  logic [NW-1:0] meta, sync;
  logic [NTX+NRX-1:0] data_prev;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= {kill_n, keep_on, rcv_oe_n, lvl_ok, tx_line, rx_line};
      sync <= meta;
    end

  logic           kill_s_n, keep_s, roe_s_n;
  logic [NRX-1:0] ok_s;
  logic [NTX+NRX-1:0] data_s;

  assign {kill_s_n, keep_s, roe_s_n, ok_s, data_s} = sync;
  assign mon_rx  = data_s[NRX-1:0];
  assign nosig_n = |ok_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) data_prev <= '0;
    else        data_prev <= data_s;

  logic activity, idle;
  assign activity = |(data_s ^ data_prev);
  assign idle     = (idle_cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        idle_cnt <= '0;
    else if (activity) idle_cnt <= '0;
    else if (!idle)    idle_cnt <= idle_cnt + 1'b1;

  logic auto_ok, want_on, rcv_want;
  assign auto_ok  = TIMEOUT_MODE ? !idle : nosig_n;
  assign want_on  = kill_s_n && (keep_s || auto_ok);
  assign rcv_want = kill_s_n && !roe_s_n && !(TIMEOUT_MODE && !keep_s && idle);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      supply_en <= 1'b0;
      drv_en    <= 1'b0;
      rcv_en    <= 1'b0;
    end else begin
      supply_en <= want_on;
      drv_en    <= want_on && supply_en;
      rcv_en    <= rcv_want;
    end
endmodule

module sercomm_pwr_ctl_chk #(
  parameter int NRX = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           kill_n,
  input logic           rcv_oe_n,
  input logic [NRX-1:0] lvl_ok,
  input logic [NRX-1:0] rx_line,
  input logic           drv_en,
  input logic           rcv_en,
  input logic           supply_en,
  input logic [NRX-1:0] mon_rx,
  input logic           nosig_n
);
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          warm <= '0;
    else if (warm != 7)  warm <= warm + 1'b1;

  a_r1_kill_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 4 && !$past(kill_n) && !$past(kill_n, 2) && !$past(kill_n, 3))
      |-> (!supply_en && !drv_en && !rcv_en));

  a_r3_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3) |-> (nosig_n == (|$past(lvl_ok, 2))));

  a_r7_monitor_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3) |-> (mon_rx == $past(rx_line, 2)));

  a_r6_rcv_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 4 && $past(rcv_oe_n, 3)) |-> !rcv_en);

  a_r8_supply_first: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 1 && $rose(drv_en)) |-> $past(supply_en));

  a_r8_drv_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> supply_en);
endmodule

bind sercomm_pwr_ctl sercomm_pwr_ctl_chk #(.NRX(NRX)) u_chk (
  .clk(clk), .rst_n(rst_n), .kill_n(kill_n), .rcv_oe_n(rcv_oe_n),
  .lvl_ok(lvl_ok), .rx_line(rx_line), .drv_en(drv_en), .rcv_en(rcv_en),
  .supply_en(supply_en), .mon_rx(mon_rx), .nosig_n(nosig_n)
);

// File: tb/sercomm_pwr_ctl_bench.sv
module sercomm_pwr_ctl_bench;
  localparam int NRX = 3;
  localparam int NTX = 2;
  localparam int T   = 40;

  logic clk = 0, rst_n = 0;
  logic kill_n = 0, keep_on = 0, rcv_oe_n = 0;
  logic [NRX-1:0] lvl_ok = '0, rx_line = '0;
  logic [NTX-1:0] tx_line = '0;

  logic l_drv, l_rcv, l_sup, l_ns;
  logic a_drv, a_rcv, a_sup, a_ns;
  logic [NRX-1:0] l_mon, a_mon;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sercomm_pwr_ctl #(.NRX(NRX), .NTX(NTX), .POLICY(0), .CLK_HZ(4), .IDLE_SEC(10))
    u_sercomm_pwr_ctl (.clk(clk), .rst_n(rst_n), .kill_n(kill_n), .keep_on(keep_on),
      .rcv_oe_n(rcv_oe_n), .lvl_ok(lvl_ok), .tx_line(tx_line), .rx_line(rx_line),
      .drv_en(l_drv), .rcv_en(l_rcv), .supply_en(l_sup), .mon_rx(l_mon), .nosig_n(l_ns));

  sercomm_pwr_ctl #(.NRX(NRX), .NTX(NTX), .POLICY(1), .CLK_HZ(4), .IDLE_SEC(10))
    u_sercomm_pwr_ctl_idle (.clk(clk), .rst_n(rst_n), .kill_n(kill_n), .keep_on(keep_on),
      .rcv_oe_n(rcv_oe_n), .lvl_ok(lvl_ok), .tx_line(tx_line), .rx_line(rx_line),
      .drv_en(a_drv), .rcv_en(a_rcv), .supply_en(a_sup), .mon_rx(a_mon), .nosig_n(a_ns));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wcyc(3);
    chk("R9", "reset enables level", {l_sup, l_drv, l_rcv}, 0);
    chk("R9", "reset enables idle", {a_sup, a_drv, a_rcv}, 0);
    rst_n = 1;
    wcyc(2);
    chk("R1", "kill low after reset", {l_sup, l_drv, l_rcv, a_sup, a_drv, a_rcv}, 0);
  endtask

  task automatic t_wake_order;
    int sup_first = 0, drv_first = 0;
    keep_on = 1;
    kill_n = 1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (l_sup && sup_first == 0) sup_first = i;
      if (l_drv && drv_first == 0) drv_first = i;
    end
    chk("R9", "supply first cycle", sup_first, 3);
    chk("R8", "driver first cycle", drv_first, 4);
    chk("R2", "keep_on level drv/sup", {l_drv, l_sup}, 2'b11);
  endtask

  task automatic t_keep_on;
    lvl_ok = '0;
    wcyc(T + 10);
    chk("R2", "keep_on drv/sup with no signal", {l_drv, l_sup, a_drv, a_sup}, 4'hf);
    chk("R11", "keep_on idle instance rcv after timeout", a_rcv, 1);
    chk("R3", "nosig low with no valid line", {l_ns, a_ns}, 0);
  endtask

  task automatic t_level;
    keep_on = 0;
    wcyc(6);
    chk("R4", "no signal drv/sup off", {l_drv, l_sup}, 0);
    chk("R4", "no signal rcv stays on", l_rcv, 1);
    lvl_ok = 3'b010;
    wcyc(6);
    chk("R3", "nosig high with one valid line", l_ns, 1);
    chk("R4", "signal back drv/sup on", {l_drv, l_sup}, 2'b11);
  endtask

  task automatic t_idle;
    rx_line[0] = ~rx_line[0];
    wcyc(3);
    chk("R7", "monitor follows rx", a_mon, rx_line);
    wcyc(T - 3);
    chk("R5", "still on before timeout", {a_drv, a_sup, a_rcv}, 3'b111);
    wcyc(8);
    chk("R5", "off after timeout", {a_drv, a_sup, a_rcv}, 0);
    chk("R4", "level instance unaffected by idle", l_drv, 1);
    tx_line[1] = ~tx_line[1];
    wcyc(6);
    chk("R10", "tx edge wakes idle instance", {a_drv, a_sup, a_rcv}, 3'b111);
    wcyc(T - 6);
    chk("R10", "timer restarted by tx edge", a_drv, 1);
  endtask

  task automatic t_rcv_gate;
    keep_on = 1;
    rcv_oe_n = 1;
    wcyc(6);
    chk("R6", "rcv gated off", {l_rcv, a_rcv}, 0);
    chk("R6", "drivers unaffected by rcv gate", {l_drv, a_drv}, 2'b11);
    rcv_oe_n = 0;
    wcyc(6);
    chk("R6", "rcv restored", {l_rcv, a_rcv}, 2'b11);
  endtask

  task automatic t_kill;
    int drv_off = 0, sup_off = 0;
    lvl_ok = 3'b111;
    kill_n = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (!l_sup && sup_off == 0) sup_off = i;
      if (!l_drv && drv_off == 0) drv_off = i;
    end
    chk("R8", "driver off no later than supply", drv_off <= sup_off, 1);
    tx_line = ~tx_line;
    rx_line = 3'b101;
    wcyc(4);
    chk("R1", "kill overrides keep_on and activity", {l_sup, l_drv, l_rcv, a_sup, a_drv, a_rcv}, 0);
    chk("R3", "nosig high during kill", l_ns, 1);
    chk("R7", "monitor active during kill", l_mon, 3'b101);
    lvl_ok = '0;
    wcyc(4);
    chk("R3", "nosig low during kill", l_ns, 0);
  endtask

  task automatic t_cancel;
    int sup_cnt = 0, drv_cnt = 0;
    kill_n = 1;
    @(negedge clk);
    kill_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sup_cnt += int'(l_sup);
      drv_cnt += int'(l_drv);
    end
    chk("R8", "cancelled wake supply pulse", sup_cnt, 1);
    chk("R8", "cancelled wake driver never on", drv_cnt, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_wake_order;
    t_keep_on;
    t_level;
    t_idle;
    t_rcv_gate;
    t_kill;
    t_cancel;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule